// File: doc/BRIEF.md
# Switched-Load Fault Supervisor

This block is the digital protection core for a bank of twelve power switches, six on the low side and six on the high side. It takes the executed control word and flags from external comparators: overcurrent and open load for each channel, supply undervoltage, temperature prewarning and temperature shutdown. An active-low hardware inhibit pin is a further input. The block decides which gates may actually be driven and builds the 16-bit status word that a serial front end shifts out.

Delays are counted in ticks of a slow timebase. The `tick` input carries one single-cycle pulse per timebase period. When a channel is in overcurrent, the supervisor tolerates it for one of two programmable delays. If the die is already warm, it cuts the channel off at once. An undervoltage that lasts long enough drops all gates. The gates come back as soon as the supply recovers, but the supply-fail flag stays latched. A thermal shutdown drops all gates and makes every status bit read high. A status-reset write is needed to leave that state. The control word is applied level-sensitively. A status reset is acted on in the cycle where `ctl_strobe` is high and control bit 0 is set.

Top module: `load_guard`

## Requirements
- R1: Control bit 14 selects the short delay: 1 picks SC_LONG_TICKS and 0 picks SC_SHORT_TICKS. When a channel's overcurrent flag is high for that many consecutive ticks, only that channel's gate drops, in the cycle after the last tick. Status bit 13 (short detected) then reads 1.
- R2: If the overcurrent flag drops for one cycle, the tick count restarts and a full delay is needed again. Cycles without a tick do not advance the count.
- R3: If the prewarning flag and a channel's overcurrent flag are high together, that channel's gate drops in the next cycle and status bit 13 is set, whatever the tick count.
- R4: An undervoltage that lasts UV_TICKS ticks turns off all gates and sets status bit 15. The gates return in the same cycle the undervoltage flag drops, while bit 15 stays 1 until a status reset.
- R5: A strobe with control bit 0 high clears status bits 13 and 15 and re-enables every channel that was cut off by a short.
- R6: After the thermal shutdown flag rises, from the next cycle on all gates are off and the status word is 0xFFFF. This holds until the flag is low and a status reset has been written. A reset written while the flag is still high has no effect.
- R7: Status bit 0 equals the prewarning flag in the same cycle, with no latching.
- R8: If control bit 15 (run) is 0 or `inh_n` is low, all gates are off and status bit 14 is 1. Otherwise bit 14 is 0.
- R9: Channel i (0..11) is controlled by control bit i+1 and reported in status bit i+1; even i are low-side and odd i are high-side. A channel commanded on reports its gate state. A channel commanded off reports its open-load flag when control bit 13 is 0, and 0 when it is 1.
- R10: With no fault and no standby, `gate_en` equals control bits 12..1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| ctl_word | input | 16 | Executed control word |
| ctl_strobe | input | 1 | Marks the cycle a new control word is executed |
| oc_flag | input | 12 | Per-channel overcurrent flags |
| ol_flag | input | 12 | Per-channel open-load flags |
| uv_flag | input | 1 | Supply undervoltage flag |
| tpw_flag | input | 1 | Temperature prewarning flag |
| tsd_flag | input | 1 | Temperature shutdown flag |
| inh_n | input | 1 | Hardware inhibit, low = standby |
| gate_en | output | 12 | Final gate enables |
| status | output | 16 | Status word |

## Verification
A wrong per-channel counter shows up at `gate_en` as a channel that drops one tick early or late, or one that never drops. The sweep over every channel and both delay settings locates such an error to the exact tick. A stuck fault latch shows as status bits 13, 15 or the all-ones word persisting past a status reset, or vanishing without one. This is visible in the first cycle after the strobe. Errors in the status multiplexing or gate masking appear at once, in the same cycle as the input pattern that exposes them.

// File: rtl/load_guard_pkg.sv
// Shared constants for the load guard: fixed status field positions that
// a downstream serial shifter decodes. Assumes channel fields start at bit 1.
package load_guard_pkg;
    localparam int ST_WARN_BIT = 0;
    localparam int CH_BASE_BIT = 1;

    // Position of the first field above the channel fields.
    function automatic int above_channels(input int nch);
        return CH_BASE_BIT + nch;
    endfunction
endpackage

// File: rtl/lg_short_chan.sv
// Per-channel short-circuit timer. It counts timebase ticks while the
// overcurrent flag is held, and latches a shut-off when the selected
// delay expires or when the die is warm. The latch is cleared only by
// the status-reset pulse. Assumes tick is a single-cycle pulse.
module lg_short_chan #(
    parameter int LONG_TICKS  = 96,
    parameter int SHORT_TICKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic oc,
    input  logic warm,
    input  logic long_sel,
    input  logic clear,
    output logic shut,
    output logic trip
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Delay currently selected by the control word.
    assign limit = long_sel ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);

    // Trip event: warm die cuts at once, otherwise the final tick of the delay.
    always_comb begin
        trip = !clear && !shut && oc && (warm || (tick && ((cnt + CW'(1)) >= limit)));
    end

    // Counter and shut-off latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            shut <= 1'b0;
        end else if (clear) begin
            cnt  <= '0;
            shut <= 1'b0;
        end else if (trip) begin
            cnt  <= '0;
            shut <= 1'b1;
        end else if (!oc || shut) begin
            cnt  <= '0;
        end else if (tick) begin
            cnt  <= cnt + CW'(1);
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAXT));
    p_drop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oc |=> (cnt == '0));
    p_warm_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oc && warm && !clear) |=> shut);
    p_shut_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shut && !clear) |=> shut);
endmodule

// File: rtl/lg_uv_timer.sv
// Undervoltage qualification timer. It counts ticks while the supply flag
// is held and asserts expired once the delay is reached. It drops
// immediately when the flag clears. fire pulses once at expiry.
module lg_uv_timer #(
    parameter int UV_TICKS = 112
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic uv,
    output logic expired,
    output logic fire
);
    localparam int CW = $clog2(UV_TICKS + 1);

    logic [CW-1:0] cnt;

    // Expiry event on the final tick of the delay.
    always_comb begin
        fire = uv && !expired && tick && ((cnt + CW'(1)) >= CW'(UV_TICKS));
    end

    // Tick counter and expired flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !uv) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (fire) begin
            cnt     <= '0;
            expired <= 1'b1;
        end else if (tick && !expired) begin
            cnt     <= cnt + CW'(1);
        end
    end

    p_uv_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !uv |=> !expired);
    p_fire_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> expired);
endmodule

// File: rtl/load_guard.sv
// Top of the load guard. It combines the per-channel short timers, the
// undervoltage timer, the thermal and supply-fail latches and the standby
// sources into the final gate enables and the status word. Assumes the
// control word is held stable and ctl_strobe marks its execution.
module load_guard #(
    parameter int SIDE_CH        = 6,
    parameter int SC_LONG_TICKS  = 96,
    parameter int SC_SHORT_TICKS = 12,
    parameter int UV_TICKS       = 112
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [2*SIDE_CH+3:0] ctl_word,
    input  logic                 ctl_strobe,
    input  logic [2*SIDE_CH-1:0] oc_flag,
    input  logic [2*SIDE_CH-1:0] ol_flag,
    input  logic                 uv_flag,
    input  logic                 tpw_flag,
    input  logic                 tsd_flag,
    input  logic                 inh_n,
    output logic [2*SIDE_CH-1:0] gate_en,
    output logic [2*SIDE_CH+3:0] status
);
    import load_guard_pkg::*;

    localparam int NCH    = 2 * SIDE_CH;
    localparam int B_OLDN = above_channels(NCH);
    localparam int B_DSEL = B_OLDN + 1;
    localparam int B_RUN  = B_OLDN + 2;

    logic [NCH-1:0] cmd;
    logic [NCH-1:0] shut;
    logic [NCH-1:0] trip;
    logic [NCH-1:0] ch_stat;
    logic           clear;
    logic           uv_expired;
    logic           uv_fire;
    logic           scd_q;
    logic           psf_q;
    logic           tsd_q;
    logic           standby;
    logic           bank_ok;

    assign cmd   = ctl_word[NCH:CH_BASE_BIT];
    assign clear = ctl_strobe && ctl_word[0];

    // One short-circuit timer per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_chan
        lg_short_chan #(
            .LONG_TICKS  (SC_LONG_TICKS),
            .SHORT_TICKS (SC_SHORT_TICKS)
        ) u_sc (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .oc       (oc_flag[i]),
            .warm     (tpw_flag),
            .long_sel (ctl_word[B_DSEL]),
            .clear    (clear),
            .shut     (shut[i]),
            .trip     (trip[i])
        );
    end

    lg_uv_timer #(.UV_TICKS(UV_TICKS)) u_uv (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .uv      (uv_flag),
        .expired (uv_expired),
        .fire    (uv_fire)
    );

    // Short-detected flag: set by any trip, cleared by status reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) scd_q <= 1'b0;
        else if (|trip)      scd_q <= 1'b1;
    end

    // Supply-fail flag: set at undervoltage expiry, cleared by status reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) psf_q <= 1'b0;
        else if (uv_fire)    psf_q <= 1'b1;
    end

    // Thermal latch: set while shutdown is flagged, released only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        tsd_q <= 1'b0;
        else if (tsd_flag) tsd_q <= 1'b1;
        else if (clear)    tsd_q <= 1'b0;
    end

    // Bank-wide permission from standby, supply and thermal state.
    always_comb begin
        standby = !ctl_word[B_RUN] || !inh_n;
        bank_ok = !standby && !(uv_flag && uv_expired) && !tsd_q;
        gate_en = bank_ok ? (cmd & ~shut) : '0;
    end

    // Per-channel status: gate state when commanded on, else open-load report.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_stat[i] = cmd[i] ? gate_en[i] : (!ctl_word[B_OLDN] && ol_flag[i]);
        end
    end

    // Status word assembly, all ones during thermal shutdown.
    always_comb begin
        if (tsd_q) status = '1;
        else       status = {psf_q, standby, scd_q, ch_stat, tpw_flag};
    end

    p_trip_sets_scd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|trip) |=> status[B_OLDN]);
    p_psf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (psf_q && !clear) |=> status[B_RUN]);
    p_tsd_gates_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_flag |=> (gate_en == '0));
    p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !inh_n |-> (gate_en == '0));
endmodule

// File: tb/load_guard_tb.sv
`timescale 1ns/1ps
module load_guard_tb;
    localparam int LONG  = 6;
    localparam int SHORT = 3;
    localparam int UVT   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] ctl = '0;
    logic        strobe = 1'b0;
    logic [11:0] oc = '0;
    logic [11:0] ol = '0;
    logic        uv = 1'b0;
    logic        tpw = 1'b0;
    logic        tsd = 1'b0;
    logic        inh_n = 1'b1;
    logic [11:0] gate_en;
    logic [15:0] status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    load_guard #(
        .SIDE_CH(6), .SC_LONG_TICKS(LONG), .SC_SHORT_TICKS(SHORT), .UV_TICKS(UVT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_word(ctl), .ctl_strobe(strobe),
        .oc_flag(oc), .ol_flag(ol), .uv_flag(uv), .tpw_flag(tpw), .tsd_flag(tsd),
        .inh_n(inh_n), .gate_en(gate_en), .status(status)
    );

    function automatic logic [15:0] cw(input logic [11:0] c, input logic oldn,
                                       input logic dsel, input logic run);
        return {run, dsel, oldn, c, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic t);
        tick = t;
        @(posedge clk);
        #1;
        tick = 1'b0;
        strobe = 1'b0;
    endtask

    task automatic sreset();
        ctl[0] = 1'b1;
        strobe = 1'b1;
        step(1'b0);
        ctl[0] = 1'b0;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(0); step(0);
        rst_n = 1'b1;
        step(0);
        // R8: reset with run bit 0 gives standby only
        chk("R8 reset status", status, 16'h4000);
        chk("R8 reset gates", {4'h0, gate_en}, 16'h0000);

        // R9, R10: sweep of command, open-load and detect-enable patterns
        for (int p = 0; p < 64; p++) begin
            logic [11:0] c;
            logic [11:0] o;
            logic        dn;
            c  = 12'(p * 12'h2D7) ^ 12'(p << 5);
            o  = 12'(p * 12'h59B);
            dn = p[0];
            ctl = cw(c, dn, p[1], 1'b1);
            ol  = o;
            #1;
            chk("R10 gates follow command", {4'h0, gate_en}, {4'h0, c});
            chk("R9 channel status", {4'h0, status[12:1]},
                {4'h0, c | (~c & (dn ? 12'h000 : o))});
        end
        ol = '0;
        step(0);

        // R1, R5: every channel, both delay settings
        for (int i = 0; i < 12; i++) begin
            for (int d = 0; d < 2; d++) begin
                int n;
                n = d ? LONG : SHORT;
                ctl = cw(12'hFFF, 1'b1, d[0], 1'b1);
                oc = 12'(1 << i);
                for (int k = 1; k < n; k++) step(1);
                chk("R1 not yet tripped", {4'h0, gate_en}, 16'h0FFF);
                step(1);
                chk("R1 only that channel off", {4'h0, gate_en}, {4'h0, 12'hFFF & ~12'(1 << i)});
                chk("R1 short bit set", {15'h0, status[13]}, 16'h1);
                oc = '0;
                sreset();
                chk("R5 channel restored", {4'h0, gate_en}, 16'h0FFF);
                chk("R5 short bit cleared", {15'h0, status[13]}, 16'h0);
            end
        end

        // R2: interruption restarts count; tickless cycles do not count
        ctl = cw(12'hFFF, 1'b1, 1'b0, 1'b1);
        oc = 12'h020;
        step(1); step(1);
        oc = '0; step(0);
        oc = 12'h020;
        step(1); step(1);
        for (int k = 0; k < 10; k++) step(0);
        chk("R2 restart after drop", {4'h0, gate_en}, 16'h0FFF);
        step(1);
        chk("R2 full delay trips", {4'h0, gate_en}, 16'h0FDF);
        oc = '0;
        sreset();

        // R3, R7: warm die cuts at once
        tpw = 1'b1; oc = 12'h004;
        #1;
        chk("R7 warning bit follows", {15'h0, status[0]}, 16'h1);
        step(0);
        chk("R3 immediate cut", {4'h0, gate_en}, 16'h0FFB);
        chk("R3 short bit", {15'h0, status[13]}, 16'h1);
        tpw = 1'b0; oc = '0;
        #1;
        chk("R7 warning bit clears", {15'h0, status[0]}, 16'h0);
        sreset();

        // R4: undervoltage qualification, release and sticky flag
        uv = 1'b1;
        for (int k = 1; k < UVT; k++) step(1);
        chk("R4 before expiry gates", {4'h0, gate_en}, 16'h0FFF);
        chk("R4 before expiry flag", {15'h0, status[15]}, 16'h0);
        step(1);
        chk("R4 expiry gates off", {4'h0, gate_en}, 16'h0000);
        chk("R4 supply fail set", {15'h0, status[15]}, 16'h1);
        uv = 1'b0;
        #1;
        chk("R4 immediate return", {4'h0, gate_en}, 16'h0FFF);
        step(0);
        chk("R4 flag sticky", {15'h0, status[15]}, 16'h1);
        sreset();
        chk("R5 supply fail cleared", {15'h0, status[15]}, 16'h0);

        // R6: thermal shutdown latch
        tsd = 1'b1;
        step(0);
        chk("R6 all ones", status, 16'hFFFF);
        chk("R6 gates off", {4'h0, gate_en}, 16'h0000);
        sreset();
        chk("R6 reset ignored while hot", status, 16'hFFFF);
        tsd = 1'b0;
        step(0); step(0);
        chk("R6 still latched after cooling", status, 16'hFFFF);
        sreset();
        chk("R6 released status", status, 16'h1FFE);
        chk("R6 released gates", {4'h0, gate_en}, 16'h0FFF);

        // R8: both standby sources
        ctl = cw(12'hFFF, 1'b1, 1'b0, 1'b0);
        #1;
        chk("R8 run bit gates", {4'h0, gate_en}, 16'h0000);
        chk("R8 run bit status", {15'h0, status[14]}, 16'h1);
        ctl = cw(12'hFFF, 1'b1, 1'b0, 1'b1);
        inh_n = 1'b0;
        #1;
        chk("R8 pin gates", {4'h0, gate_en}, 16'h0000);
        chk("R8 pin status", {15'h0, status[14]}, 16'h1);
        inh_n = 1'b1;
        #1;
        chk("R8 normal gates", {4'h0, gate_en}, 16'h0FFF);
        chk("R8 normal status", {15'h0, status[14]}, 16'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule